// File: doc/BRIEF.md
# Indirect Byte-Register Access Bridge

This block puts a private bank of byte-wide controller registers behind one 32-bit window word on a small memory-mapped host bus. The host does not address the inner bytes directly. It stores a command into the window with an 8-bit inner address, a data byte and a direction flag. The bridge then spends a fixed number of core cycles on the inner access, and a busy flag in the window stays up for that whole time. A write needs only the single store. A read needs two steps: the host stores the address with the direction flag clear, then polls the window until busy drops, and then takes the byte from the top of the same word.

Four more host registers sit beside the window. A general control register holds a soft-reset bit and a 2-bit clock-mode field, and both drive output pins. Three interrupt registers cover a transmit event and a receive event: an enable mask, a write-one-to-clear register and a sticky status register. The interrupt pin is high whenever an enabled status bit is set.

Top module: `byte_window_bridge`

## Requirements
- R1: After the reset input, every host register (control 0x00, window 0x04, mask 0x08, status 0x10) reads as zero, and `irq`, `core_soft_rst` and `core_clk_mode` are low.
- R2: A store to the window at 0x04 holds window bit 23 (busy) high for exactly 4 core cycles. When bit 16 of the stored word is 1, the byte in bits [15:8] is written into the inner register addressed by bits [7:0] at the moment busy clears.
- R3: A store with bit 16 at 0 starts a read. Once busy has cleared, window bits [31:24] hold the inner register's value, bits [7:0] echo the address and bit 16 reads 0.
- R4: A window store that arrives while busy is high is ignored. The latched address and data fields do not change, and no inner register is touched.
- R5: While control bit 0 (soft reset) is 1, every inner register returns to 0x00, busy is held low, an access in progress is cancelled, all window fields read 0 and window stores are ignored. The control register keeps its value.
- R6: Control bits [2:1] drive `core_clk_mode` (0 clock off, 1 gated normal clock, 2 free-running debug clock). All four codes read back unchanged.
- R7: A pulse on `tx_evt` sets status bit 1, and a pulse on `rx_evt` sets status bit 2. Status reads at 0x10 and the bits stay set until cleared.
- R8: Writing a 1 to bit 1 or bit 2 of the clear register at 0x0C clears the matching status bit. Zero bits leave their status bit alone. An event in the same cycle as its clear leaves the bit set.
- R9: The mask register at 0x08 stores bits 1 and 2 only, and its other bits read 0. `irq` is the OR over bits 1 and 2 of (status AND mask).
- R10: Stores to the status register or to an unused offset (0x14) change no register, and an unused offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Host access strobe |
| bus_wr | input | 1 | Host store when 1 (with bus_sel) |
| bus_addr | input | BUS_AW (5) | Host byte offset |
| bus_wdata | input | 32 | Host store data |
| bus_rdata | output | 32 | Host read data for bus_addr (combinational) |
| tx_evt | input | 1 | Transmit event pulse |
| rx_evt | input | 1 | Receive event pulse |
| irq | output | 1 | Interrupt request |
| core_clk_mode | output | 2 | Clock-mode field of the control register |
| core_soft_rst | output | 1 | Soft-reset bit of the control register |

## Verification
The window is driven with a full sweep: every one of the 256 inner addresses is written with a value computed from its address, and then every address is read back. This catches swapped or dropped address lines and stale read data, and the busy flag is sampled in each cycle of every access, so a one-cycle error in the busy length shows up. Stores are also issued during busy, and a soft reset is raised both at rest and in the middle of an access, which separates ignoring or cancelling an access from letting it complete. The interrupt logic is tried with all 16 combinations of mask and pending events, plus a clear that lands in the same cycle as its event.

// File: rtl/bwb_pkg.sv
package bwb_pkg;

  localparam int OFS_CTRL = 'h00;
  localparam int OFS_WIN  = 'h04;
  localparam int OFS_MASK = 'h08;
  localparam int OFS_CLR  = 'h0C;
  localparam int OFS_STAT = 'h10;

  localparam int WIN_DIR_BIT  = 16;
  localparam int WIN_BUSY_BIT = 23;

  localparam logic [2:0] EVT_BITS = 3'b110;  // bit1 transmit, bit2 receive

  typedef enum logic [1:0] {
    CLK_OFF   = 2'd0,
    CLK_GATED = 2'd1,
    CLK_FREE  = 2'd2,
    CLK_RSVD  = 2'd3
  } clk_mode_e;

  typedef struct packed {
    logic       wr;
    logic [7:0] wdata;
    logic [7:0] addr;
  } win_req_t;

  function automatic logic [31:0] pack_window(logic [7:0] rd_byte, logic busy, win_req_t r);
    return {rd_byte, busy, 6'b0, r.wr, r.wdata, r.addr};
  endfunction

  function automatic logic irq_pending(logic [2:0] status, logic [2:0] mask);
    return |(status & mask & EVT_BITS);
  endfunction

endpackage

// File: rtl/bwb_window_seq.sv
module bwb_window_seq
  import bwb_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     soft_rst,
  input  logic     req_valid,
  input  win_req_t req,
  output logic     busy,
  output logic     commit,
  output win_req_t cur
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(BUSY_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          accept;

  assign accept = req_valid && !busy && !soft_rst;
  assign commit = busy && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      cur  <= '0;
    end else if (soft_rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      cur  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= '0;
      cur  <= req;
    end else if (busy) begin
      if (commit) busy <= 1'b0;
      else        cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bwb_reg_bank.sv
module bwb_reg_bank #(
  parameter int         AW       = 8,
  parameter logic [7:0] DEFAULTV = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DEFAULTV;
      rdata <= '0;
    end else if (clear) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DEFAULTV;
      rdata <= '0;
    end else begin
      if (we) mem[addr] <= wdata;
      if (re) rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/bwb_irq_regs.sv
module bwb_irq_regs
  import bwb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mask_we,
  input  logic       clr_we,
  input  logic [2:0] wbits,
  input  logic       tx_evt,
  input  logic       rx_evt,
  output logic [2:0] mask,
  output logic [2:0] status,
  output logic       irq
);
  logic [2:0] set_bits, clr_bits;

  assign set_bits = {rx_evt, tx_evt, 1'b0};
  assign clr_bits = clr_we ? wbits : 3'b000;
  assign irq      = irq_pending(status, mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask   <= '0;
      status <= '0;
    end else begin
      if (mask_we) mask <= wbits & EVT_BITS;
      status <= ((status & ~clr_bits) | set_bits) & EVT_BITS;
    end
  end
endmodule

// File: rtl/byte_window_bridge.sv
module byte_window_bridge
  import bwb_pkg::*;
#(
  parameter int BUS_AW      = 5,
  parameter int BANK_AW     = 8,
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tx_evt,
  input  logic              rx_evt,
  output logic              irq,
  output logic [1:0]        core_clk_mode,
  output logic              core_soft_rst
);
  localparam logic [BUS_AW-1:0] A_CTRL = BUS_AW'(OFS_CTRL);
  localparam logic [BUS_AW-1:0] A_WIN  = BUS_AW'(OFS_WIN);
  localparam logic [BUS_AW-1:0] A_MASK = BUS_AW'(OFS_MASK);
  localparam logic [BUS_AW-1:0] A_CLR  = BUS_AW'(OFS_CLR);
  localparam logic [BUS_AW-1:0] A_STAT = BUS_AW'(OFS_STAT);

  logic       store, ctrl_we, win_we, mask_we, clr_we;
  logic [2:0] ctrl_q, mask_q, status_q;
  logic       win_busy, win_commit;
  win_req_t   req_in, win_cur;
  logic [7:0] win_addr_q, rd_byte;
  clk_mode_e  mode;
  logic       unused_hi;

  assign store   = bus_sel && bus_wr;
  assign ctrl_we = store && (bus_addr == A_CTRL);
  assign win_we  = store && (bus_addr == A_WIN);
  assign mask_we = store && (bus_addr == A_MASK);
  assign clr_we  = store && (bus_addr == A_CLR);
  assign unused_hi = ^bus_wdata[31:17];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= bus_wdata[2:0];
  end

  assign mode          = clk_mode_e'(ctrl_q[2:1]);
  assign core_clk_mode = mode;
  assign core_soft_rst = ctrl_q[0];

  assign req_in.addr  = bus_wdata[7:0];
  assign req_in.wdata = bus_wdata[15:8];
  assign req_in.wr    = bus_wdata[WIN_DIR_BIT];

  bwb_window_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (core_soft_rst),
    .req_valid(win_we),
    .req      (req_in),
    .busy     (win_busy),
    .commit   (win_commit),
    .cur      (win_cur)
  );

  assign win_addr_q = win_cur.addr;

  bwb_reg_bank #(.AW(BANK_AW)) u_bank (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(core_soft_rst),
    .we   (win_commit && win_cur.wr),
    .re   (win_commit && !win_cur.wr),
    .addr (win_cur.addr[BANK_AW-1:0]),
    .wdata(win_cur.wdata),
    .rdata(rd_byte)
  );

  bwb_irq_regs u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .mask_we(mask_we),
    .clr_we (clr_we),
    .wbits  (bus_wdata[2:0]),
    .tx_evt (tx_evt),
    .rx_evt (rx_evt),
    .mask   (mask_q),
    .status (status_q),
    .irq    (irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata = {29'b0, ctrl_q};
      A_WIN:   bus_rdata = pack_window(rd_byte, win_busy, win_cur);
      A_MASK:  bus_rdata = {29'b0, mask_q};
      A_STAT:  bus_rdata = {29'b0, status_q};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bwb_checker.sv
module bwb_checker #(
  parameter int BUSY_CYCLES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       busy,
  input logic       commit,
  input logic [7:0] lat_addr,
  input logic       tx_evt,
  input logic       rx_evt,
  input logic       clr_we,
  input logic [2:0] clr_bits,
  input logic [2:0] status,
  input logic [2:0] mask,
  input logic       irq
);
  localparam int RW = $clog2(BUSY_CYCLES + 1);

  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= '0;
    else if (!busy) run <= '0;
    else           run <= run + 1'b1;
  end

  a_r2_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run < RW'(BUSY_CYCLES)));

  a_r2_commit_last: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (busy && run == RW'(BUSY_CYCLES - 1)));

  a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (busy && !commit) |=> $stable(lat_addr));

  a_r5_soft_idle: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !busy);

  a_r7_tx_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tx_evt |=> status[1]);

  a_r7_rx_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt |=> status[2]);

  a_r8_clear_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_bits[1] && !tx_evt) |=> !status[1]);

  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask[2:1] == 2'b00) |-> !irq);
endmodule

bind byte_window_bridge bwb_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_bwb_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .soft_rst(core_soft_rst),
  .busy    (win_busy),
  .commit  (win_commit),
  .lat_addr(win_addr_q),
  .tx_evt  (tx_evt),
  .rx_evt  (rx_evt),
  .clr_we  (clr_we),
  .clr_bits(bus_wdata[2:0]),
  .status  (status_q),
  .mask    (mask_q),
  .irq     (irq)
);

// File: tb/test_byte_window_bridge.sv
module test_byte_window_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_evt = 1'b0, rx_evt = 1'b0;
  logic        irq;
  logic [1:0]  core_clk_mode;
  logic        core_soft_rst;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  byte_window_bridge i_byte_window_bridge (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_evt(tx_evt), .rx_evt(rx_evt), .irq(irq),
    .core_clk_mode(core_clk_mode), .core_soft_rst(core_soft_rst)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 29 + 7) ^ 'h5A);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic store(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic win_access(input logic [7:0] a, input logic [7:0] d, input logic dir,
                            output logic [7:0] rdb);
    logic [31:0] w;
    store(5'h04, {15'h0, dir, d, a});
    for (int i = 0; i < 4; i++) begin
      peek(5'h04, w);
      chk("R2 busy high during access", 32'(w[23]), 32'd1);
      @(negedge clk);
    end
    peek(5'h04, w);
    chk("R2 busy low after 4 cycles", 32'(w[23]), 32'd0);
    chk("R3 address echo", 32'(w[7:0]), 32'(a));
    rdb = w[31:24];
  endtask

  task automatic pulse_evt(input logic t, input logic r);
    @(negedge clk);
    tx_evt = t; rx_evt = r;
    @(negedge clk);
    tx_evt = 1'b0; rx_evt = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [7:0]  b;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(5'h00, w); chk("R1 control reset", w, 32'h0);
    peek(5'h04, w); chk("R1 window reset", w, 32'h0);
    peek(5'h08, w); chk("R1 mask reset", w, 32'h0);
    peek(5'h10, w); chk("R1 status reset", w, 32'h0);
    chk("R1 irq/mode/soft low", {29'h0, irq, core_clk_mode, core_soft_rst}, 32'h0);

    // R2/R3 full address sweep
    for (int a = 0; a < 256; a++) win_access(8'(a), pat(a), 1'b1, b);
    for (int a = 0; a < 256; a++) begin
      win_access(8'(a), 8'h00, 1'b0, b);
      chk("R3 read data", 32'(b), 32'(pat(a)));
    end
    peek(5'h04, w); chk("R3 direction bit reads 0 after read", 32'(w[16]), 32'd0);

    // R4 store during busy ignored
    store(5'h04, {15'h0, 1'b1, 8'hC3, 8'h10});
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h04;
    bus_wdata = {15'h0, 1'b1, 8'h99, 8'h20};
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    peek(5'h04, w);
    chk("R4 latched address kept", 32'(w[7:0]), 32'h10);
    chk("R4 latched data kept", 32'(w[15:8]), 32'hC3);
    repeat (3) @(negedge clk);
    win_access(8'h20, 8'h00, 1'b0, b);
    chk("R4 ignored store did not write", 32'(b), 32'(pat('h20)));
    win_access(8'h10, 8'h00, 1'b0, b);
    chk("R4 first store committed", 32'(b), 32'hC3);

    // R5 soft reset at rest
    store(5'h00, 32'h3);
    @(negedge clk);
    chk("R5 soft reset pin", 32'(core_soft_rst), 32'd1);
    store(5'h04, {15'h0, 1'b1, 8'h55, 8'h33});
    @(negedge clk);
    peek(5'h04, w); chk("R5 window idle and cleared in soft reset", w, 32'h0);
    peek(5'h00, w); chk("R5 control kept", w, 32'h3);
    store(5'h00, 32'h2);
    win_access(8'h33, 8'h00, 1'b0, b);
    chk("R5 inner register back to default", 32'(b), 32'h0);
    win_access(8'hFF, 8'h00, 1'b0, b);
    chk("R5 top inner register back to default", 32'(b), 32'h0);

    // R5 soft reset cancels access in progress
    win_access(8'h44, 8'h12, 1'b1, b);
    store(5'h04, {15'h0, 1'b1, 8'hAB, 8'h44});
    store(5'h00, 32'h3);
    @(negedge clk);
    peek(5'h04, w); chk("R5 busy dropped by soft reset", 32'(w[23]), 32'd0);
    store(5'h00, 32'h0);
    win_access(8'h44, 8'h00, 1'b0, b);
    chk("R5 cancelled write not applied", 32'(b), 32'h0);

    // R6 clock mode sweep
    for (int m = 0; m < 4; m++) begin
      store(5'h00, 32'(m << 1));
      chk("R6 clock mode pin", 32'(core_clk_mode), 32'(m));
      peek(5'h00, w); chk("R6 clock mode readback", w, 32'(m << 1));
    end
    store(5'h00, 32'h0);

    // R7/R9 all mask x event combinations
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 4; s++) begin
        store(5'h0C, 32'h6);
        store(5'h08, 32'(m << 1));
        pulse_evt(s[0], s[1]);
        peek(5'h10, w); chk("R7 status after events", w, 32'(s << 1));
        chk("R9 irq equals masked status", 32'(irq), 32'((s & m) != 0));
      end
    end

    // R9 mask keeps only event bits
    store(5'h08, 32'hFFFF_FFFF);
    peek(5'h08, w); chk("R9 mask stores bits 1 and 2 only", w, 32'h6);

    // R8 clear behaviour
    pulse_evt(1'b1, 1'b1);
    store(5'h0C, 32'h2);
    peek(5'h10, w); chk("R8 clear transmit only", w, 32'h4);
    store(5'h0C, 32'h0);
    peek(5'h10, w); chk("R8 zero clear leaves status", w, 32'h4);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h0C; bus_wdata = 32'h6; tx_evt = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; tx_evt = 1'b0;
    peek(5'h10, w); chk("R8 event beats same-cycle clear", w, 32'h2);

    // R10 stores to status / unused offsets
    store(5'h10, 32'h0);
    peek(5'h10, w); chk("R10 status not writable", w, 32'h2);
    store(5'h14, 32'hFFFF_FFFF);
    peek(5'h14, w); chk("R10 unused offset reads 0", w, 32'h0);
    peek(5'h00, w); chk("R10 control untouched", w, 32'h0);
    peek(5'h08, w); chk("R10 mask untouched", w, 32'h6);
    chk("R10 irq unchanged", 32'(irq), 32'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule